// File: doc/BRIEF.md
# Serial Conversion Sequencer with Result Shifter

This block sequences one analog-to-digital conversion after a control byte has been accepted by the serial front end. It counts falling edges of the serial clock after the start event and drives the strobe output at fixed counts. It steps a 14-bit successive-approximation trial register against an external comparator decision and shifts the result out MSB first on the serial data output. The serial clock is sampled into the system clock domain, and all state is synchronous to the system clock.

The clock mode is chosen with each start. In external-clock mode the serial clock paces the acquisition, every bit decision and the data output. A short frame is 24 serial clocks and a long frame is 32. In internal-clock mode a divided system clock runs the conversion. The finished word is held in a shift register that the host empties later with further serial clocks. In unipolar operation the result is sent as straight binary. In bipolar operation it is sent as two's complement, which is the comparator's offset-binary code with the top bit inverted. A calibration operation only times the strobe.

Top module: `ser_conv_seq`

## Requirements
- R1: After reset the block is in internal-clock mode: `sdo_o`=0, `sstrb_o`=1, `sstrb_oe_o`=1, and `sdo_oe_o`=0 while `cs_ni` is high.
- R2: External clock, short frame (`op_i`=2'b00, `int_clk_i`=0): `sstrb_o` is high from the 7th counted serial-clock falling edge after `start_i` until the 8th, and is low at every other point of the frame.
- R3: External clock, short frame: the result MSB is driven on `sdo_o` from the 8th falling edge, and each following edge brings the next bit, down to the LSB at edge 21. Edges 22 and 23 drive 0, and the frame ends at edge 24. `sdo_o` changes only after a counted falling edge or a start.
- R4: External clock, long frame (`op_i`=2'b11): the strobe pulse spans edges 15 to 16, the MSB appears at edge 16 and the LSB at edge 29, and edges 30 and 31 drive 0.
- R5: With `unipolar_i`=1 the sent word equals the comparator code. With `unipolar_i`=0 it is that code with bit 13 inverted (two's complement).
- R6: The trial register `trial_o` is loaded with 14'h2000 at the strobe edge. Each decision keeps the current trial bit when `cmp_i`=1, clears it otherwise, and sets the next lower bit.
- R7: While `cs_ni` is high, `sdo_oe_o` is 0, `sstrb_oe_o` is 0 in external-clock mode, and serial-clock falling edges are not counted.
- R8: Internal clock (`int_clk_i`=1): `sstrb_o` falls at edge 7 (short) or 15 (long) and stays low while 14 decisions run on the divided clock. It then rises with the MSB already on `sdo_o`.
- R9: Internal clock: after the strobe rises, each counted falling edge shifts out the next lower bit. Zeros follow the LSB.
- R10: In internal-clock mode `sstrb_oe_o` is 1 regardless of `cs_ni`.
- R11: Calibration (`op_i`=2'b01): with the internal clock, `sstrb_o` is low for CAL_STEPS divided-clock ticks and then goes high. With the external clock, it is high for CAL_STEPS counted falling edges and then goes low.
- R12: A new `start_i` aborts any operation in progress and restarts the edge count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| cs_ni | input | 1 | Active-low chip select |
| start_i | input | 1 | One-cycle pulse: control byte accepted |
| unipolar_i | input | 1 | 1 = straight binary, 0 = two's complement |
| int_clk_i | input | 1 | 1 = internal conversion clock |
| op_i | input | 2 | 00 short, 11 long, 01 calibrate, 10 no operation |
| cmp_i | input | 1 | Comparator: input at or above trial |
| trial_o | output | 14 | Successive-approximation trial word (offset binary) |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| sstrb_o | output | 1 | Strobe |
| sstrb_oe_o | output | 1 | Drive enable for sstrb_o |

## Verification
The assertions assume that `cs_ni`, `start_i` and the mode inputs change only while the serial clock is low and well away from a synchronised falling edge. They also assume that `cmp_i` is a settled function of `trial_o`. The bench keeps within this: it drives every input on the falling system clock edge, holds each serial clock phase for several system clocks, and pulses `start_i` only between serial clock cycles. Its comparator model is a plain magnitude compare of a fixed code against `trial_o`.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic [1:0] {
    OP_SHORT = 2'b00,
    OP_CAL   = 2'b01,
    OP_NONE  = 2'b10,
    OP_LONG  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_EXT_CONV,
    ST_INT_CONV,
    ST_INT_READ,
    ST_CAL
  } state_e;
endpackage

// File: rtl/ser_timebase.sv
module ser_timebase #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o,
  output logic tick_o
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [2:0]       sync_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], sclk_i};
      div_q  <= tick_o ? '0 : div_q + 1'b1;
    end
  end

  assign fall_o = sync_q[2] & ~sync_q[1];
  assign tick_o = (div_q == DIV_W'(DIV - 1));
endmodule

// File: rtl/ser_sar.sv
module ser_sar #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         done_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_o <= '0;
      mask_q  <= '0;
    end else if (load_i) begin
      trial_o <= {1'b1, {(W-1){1'b0}}};
      mask_q  <= {1'b1, {(W-1){1'b0}}};
    end else if (step_i && mask_q != '0) begin
      // keep or drop the bit under test, then try the next lower one
      trial_o <= (cmp_i ? trial_o : (trial_o & ~mask_q)) | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end

  assign done_o = (mask_q == '0);
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/ser_conv_seq.sv
module ser_conv_seq
  import ser_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int DIV         = 4,
  parameter int CAL_STEPS   = 20,
  parameter int SHORT_STB   = 7,
  parameter int LONG_STB    = 15,
  parameter int SHORT_FRAME = 24,
  parameter int LONG_FRAME  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni,
  input  logic             start_i,
  input  logic             unipolar_i,
  input  logic             int_clk_i,
  input  logic [1:0]       op_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             sstrb_o,
  output logic             sstrb_oe_o
);
  localparam int CNT_W = $clog2(LONG_FRAME + 1);
  localparam int CAL_W = $clog2(CAL_STEPS + 1);

  state_e           state_q;
  logic             int_q, bip_q, long_q, sstrb_q, ext_sdo_q;
  logic [CNT_W-1:0] edge_cnt, cnt_nx, stb_at, frame_len;
  logic [CAL_W-1:0] cal_cnt;
  logic             sclk_fall, tick, fall_ev, in_window, cal_unit;
  logic             sar_load, sar_step, sar_done;
  logic             sh_load, sh_shift, sh_msb;
  logic [RES_W-1:0] sh_data;

  ser_timebase #(.DIV(DIV)) i_timebase (
    .clk_i, .rst_ni, .sclk_i, .fall_o(sclk_fall), .tick_o(tick)
  );

  ser_sar #(.W(RES_W)) i_sar (
    .clk_i, .rst_ni, .load_i(sar_load), .step_i(sar_step), .cmp_i,
    .trial_o, .done_o(sar_done)
  );

  ser_shift #(.W(RES_W)) i_shift (
    .clk_i, .rst_ni, .clr_i(start_i), .load_i(sh_load), .data_i(sh_data),
    .shift_i(sh_shift), .msb_o(sh_msb)
  );

  assign fall_ev   = sclk_fall & ~cs_ni;
  assign cnt_nx    = edge_cnt + 1'b1;
  assign stb_at    = long_q ? CNT_W'(LONG_STB) : CNT_W'(SHORT_STB);
  assign frame_len = long_q ? CNT_W'(LONG_FRAME) : CNT_W'(SHORT_FRAME);
  assign in_window = (cnt_nx > stb_at) && (cnt_nx <= stb_at + CNT_W'(RES_W));
  assign cal_unit  = int_q ? tick : fall_ev;

  assign sar_load = !start_i && state_q == ST_ACQ && fall_ev && cnt_nx == stb_at;
  assign sar_step = !start_i &&
                    ((state_q == ST_EXT_CONV && fall_ev && in_window) ||
                     (state_q == ST_INT_CONV && !sar_done && tick));
  assign sh_load  = !start_i && state_q == ST_INT_CONV && sar_done;
  assign sh_data  = {trial_o[RES_W-1] ^ bip_q, trial_o[RES_W-2:0]};
  assign sh_shift = !start_i && state_q == ST_INT_READ && fall_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      int_q     <= 1'b1;
      bip_q     <= 1'b1;
      long_q    <= 1'b0;
      sstrb_q   <= 1'b1;
      ext_sdo_q <= 1'b0;
      edge_cnt  <= '0;
      cal_cnt   <= '0;
    end else if (start_i) begin
      edge_cnt  <= '0;
      cal_cnt   <= '0;
      ext_sdo_q <= 1'b0;
      if (op_i != OP_NONE) begin
        int_q  <= int_clk_i;
        bip_q  <= ~unipolar_i;
        long_q <= (op_i == OP_LONG);
      end
      case (op_i)
        OP_CAL: begin
          state_q <= ST_CAL;
          sstrb_q <= ~int_clk_i;
        end
        OP_SHORT, OP_LONG: begin
          state_q <= ST_ACQ;
          sstrb_q <= int_clk_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end else begin
      case (state_q)
        ST_ACQ: if (fall_ev) begin
          edge_cnt <= cnt_nx;
          if (cnt_nx == stb_at) begin
            sstrb_q <= ~int_q;
            state_q <= int_q ? ST_INT_CONV : ST_EXT_CONV;
          end
        end
        ST_EXT_CONV: if (fall_ev) begin
          edge_cnt  <= cnt_nx;
          sstrb_q   <= 1'b0;
          // decision bit leaves on the same edge it is made; MSB flips for bipolar
          ext_sdo_q <= in_window & (cmp_i ^ (bip_q && cnt_nx == stb_at + 1'b1));
          if (cnt_nx == frame_len) state_q <= ST_IDLE;
        end
        ST_INT_CONV: if (sar_done) begin
          sstrb_q <= 1'b1;
          state_q <= ST_INT_READ;
        end
        ST_CAL: if (cal_unit) begin
          cal_cnt <= cal_cnt + 1'b1;
          if (cal_cnt == CAL_W'(CAL_STEPS - 1)) begin
            sstrb_q <= int_q;
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdo_o      = int_q ? sh_msb : ext_sdo_q;
  assign sdo_oe_o   = ~cs_ni;
  assign sstrb_o    = sstrb_q;
  assign sstrb_oe_o = int_q | ~cs_ni;
endmodule

// File: rtl/ser_conv_seq_chk.sv
module ser_conv_seq_chk
  import ser_pkg::*;
#(
  parameter int RES_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             start_i,
  input logic             int_q,
  input logic             fall_ev,
  input logic             sar_load,
  input state_e           state_q,
  input logic [RES_W-1:0] trial_o,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             sstrb_o,
  input logic             sstrb_oe_o
);
  p_strobe_one_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_q && state_q == ST_EXT_CONV && sstrb_o && fall_ev && !start_i) |=> !sstrb_o);

  p_sdo_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_q && $past(!int_q) && !$past(fall_ev) && !$past(start_i)) |-> $stable(sdo_o));

  p_trial_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sar_load && !start_i) |=> trial_o == {1'b1, {(RES_W-1){1'b0}}});

  p_sdo_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_oe_o);

  p_strobe_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !int_q) |-> !sstrb_oe_o);

  p_int_busy_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INT_CONV) |-> !sstrb_o);

  p_int_driven_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q |-> sstrb_oe_o);
endmodule

bind ser_conv_seq ser_conv_seq_chk #(.RES_W(RES_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .start_i(start_i),
  .int_q(int_q), .fall_ev(fall_ev), .sar_load(sar_load), .state_q(state_q),
  .trial_o(trial_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .sstrb_o(sstrb_o), .sstrb_oe_o(sstrb_oe_o)
);

// File: tb/test_ser_conv_seq.sv
module test_ser_conv_seq;
  import ser_pkg::*;
  localparam int W = 14, DIV = 4, CAL = 20;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, start = 0, uni = 0, intc = 0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] code = '0, trial;
  logic sdo, sdo_oe, stb, stb_oe, cmp;
  logic smp_sdo, smp_stb;
  int checks = 0, errors = 0;
  bit finished = 0;

  // fields: code[16:3], unipolar[2], internal clock[1], long frame[0]
  localparam logic [16:0] VEC [6] = '{
    {14'h2A5C, 1'b1, 1'b0, 1'b0},
    {14'h1234, 1'b0, 1'b0, 1'b0},
    {14'h0000, 1'b1, 1'b0, 1'b1},
    {14'h3FFF, 1'b0, 1'b0, 1'b1},
    {14'h2001, 1'b1, 1'b1, 1'b0},
    {14'h1F00, 1'b0, 1'b1, 1'b1}
  };

  always #5 clk = ~clk;
  assign cmp = (code >= trial);

  ser_conv_seq #(.RES_W(W), .DIV(DIV), .CAL_STEPS(CAL)) i_ser_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .start_i(start),
    .unipolar_i(uni), .int_clk_i(intc), .op_i(op), .cmp_i(cmp), .trial_o(trial),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sstrb_o(stb), .sstrb_oe_o(stb_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic u, input logic ic, input logic [1:0] o);
    @(negedge clk);
    uni = u; intc = ic; op = o; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic sclk_cyc();
    sclk = 1;
    repeat (6) @(negedge clk);
    sclk = 0;
    repeat (5) @(negedge clk);
    smp_sdo = sdo;
    smp_stb = stb;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] fmt(input logic [W-1:0] c, input logic u);
    return u ? c : (c ^ {1'b1, {(W-1){1'b0}}});
  endfunction

  task automatic run_ext(input logic [W-1:0] c, input logic u, input logic lng);
    int sa, fl, nstb, kstb;
    logic [W-1:0] word;
    logic zeros;
    string tag;
    code = c; sa = lng ? 15 : 7; fl = lng ? 32 : 24;
    nstb = 0; kstb = 0; word = '0; zeros = 0;
    tag = lng ? "R4" : "R2";
    start_op(u, 1'b0, lng ? OP_LONG : OP_SHORT);
    for (int k = 1; k <= fl; k++) begin
      sclk_cyc();
      if (smp_stb) begin nstb++; kstb = k; end
      if (k == sa) chk("R6 trial at strobe", 32'(trial), 32'h2000);
      if (k > sa && k <= sa + W) word = {word[W-2:0], smp_sdo};
      else if (k > sa + W) zeros |= smp_sdo;
    end
    chk({tag, " strobe count"}, nstb, 1);
    chk({tag, " strobe edge"}, kstb, sa);
    chk(lng ? "R4 R5 word" : "R3 R5 word", 32'(word), 32'(fmt(c, u)));
    chk(lng ? "R4 zero fill" : "R3 zero fill", 32'(zeros), 0);
  endtask

  task automatic run_int(input logic [W-1:0] c, input logic u, input logic lng);
    int sa, n;
    logic [W-1:0] word;
    code = c; sa = lng ? 15 : 7;
    start_op(u, 1'b1, lng ? OP_LONG : OP_SHORT);
    for (int k = 1; k <= sa; k++) begin
      sclk_cyc();
      if (k == sa - 1) chk("R8 strobe idle high", 32'(smp_stb), 1);
      if (k == sa) chk("R8 strobe low at start", 32'(smp_stb), 0);
    end
    n = 0;
    while (!stb && n < 1000) begin @(negedge clk); n++; end
    chk("R8 conversion length", 32'(n >= 12 * DIV && n < 1000), 1);
    word = {{(W-1){1'b0}}, sdo};
    for (int i = 1; i < W; i++) begin
      sclk_cyc();
      word = {word[W-2:0], smp_sdo};
    end
    chk("R9 R5 word", 32'(word), 32'(fmt(c, u)));
    sclk_cyc();
    chk("R9 zero after lsb", 32'(smp_sdo), 0);
    sclk_cyc();
    chk("R9 zero after lsb 2", 32'(smp_sdo), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 sdo", 32'(sdo), 0);
    chk("R1 strobe", 32'(stb), 1);
    chk("R1 strobe oe", 32'(stb_oe), 1);
    chk("R1 sdo oe", 32'(sdo_oe), 0);
    cs_n = 0;
    @(negedge clk);
    chk("R7 sdo oe with cs low", 32'(sdo_oe), 1);

    for (int i = 0; i < 6; i++) begin
      if (VEC[i][1]) run_int(VEC[i][16:3], VEC[i][2], VEC[i][0]);
      else           run_ext(VEC[i][16:3], VEC[i][2], VEC[i][0]);
    end

    // R7: clocks with cs high are not counted
    code = 14'h0AAA;
    start_op(1'b1, 1'b0, OP_SHORT);
    repeat (3) sclk_cyc();
    cs_n = 1;
    @(negedge clk);
    chk("R7 sdo hiz", 32'(sdo_oe), 0);
    chk("R7 strobe hiz", 32'(stb_oe), 0);
    repeat (5) sclk_cyc();
    cs_n = 0;
    repeat (3) sclk_cyc();
    chk("R7 edge count held", 32'(smp_stb), 0);
    sclk_cyc();
    chk("R7 strobe after resume", 32'(smp_stb), 1);

    // R12: restart mid-frame
    start_op(1'b1, 1'b0, OP_SHORT);
    repeat (5) sclk_cyc();
    start_op(1'b1, 1'b0, OP_SHORT);
    repeat (6) sclk_cyc();
    chk("R12 no strobe before 7", 32'(smp_stb), 0);
    sclk_cyc();
    chk("R12 strobe at 7 after restart", 32'(smp_stb), 1);

    // R10: internal mode keeps strobe driven with cs high
    start_op(1'b1, 1'b1, OP_SHORT);
    cs_n = 1;
    repeat (2) @(negedge clk);
    chk("R10 strobe oe", 32'(stb_oe), 1);
    chk("R10 strobe level", 32'(stb), 1);
    cs_n = 0;

    // R11: internal calibration
    start_op(1'b1, 1'b1, OP_CAL);
    @(negedge clk);
    chk("R11 int cal low", 32'(stb), 0);
    n = 0;
    while (!stb && n < 1000) begin @(negedge clk); n++; end
    chk("R11 int cal length", 32'(n >= (CAL - 2) * DIV && n <= (CAL + 1) * DIV), 1);

    // R11: external calibration
    start_op(1'b1, 1'b0, OP_CAL);
    repeat (2) @(negedge clk);
    chk("R11 ext cal high", 32'(stb), 1);
    repeat (CAL - 1) sclk_cyc();
    chk("R11 ext cal still high", 32'(smp_stb), 1);
    sclk_cyc();
    chk("R11 ext cal end", 32'(smp_stb), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule